// File: doc/BRIEF.md
# Configuration-Window Host Bridge Translator

This block sits between the hart-side load/store port and the root-bus request port of a root complex. A hart access that lands in a fixed 256 MiB configuration window is turned into a configuration read or write request. The request carries bus, device, function and register fields taken straight from the window offset. A hart access that lands in the outbound memory region is passed on with its address unchanged, but only when an enabled device window claims it. Every other access is answered with an error.

Only one request is in flight at a time. The hart response is held back until the downstream completion arrives, or until a timeout expires. For configuration reads, the block makes up the completion data itself when the target is known to be absent on the root bus or when the completion reports an unsupported request. In both cases the hart sees all-ones data rather than an error.

Top module: `hb_cfg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `cfg_req_valid` and `mem_req_valid` are 0.
- R2: An accepted access with address in [CFG_BASE, CFG_BASE + 2^28) issues one `cfg_req_valid` pulse on the cycle after acceptance. Its fields are bus = addr[27:20], device = addr[19:15], function = addr[14:12] and register = addr[11:0], with `cfg_req_write` equal to the hart's write flag and `cfg_req_wdata` equal to the hart's write data.
- R3: A configuration access whose target is on bus ROOT_BUS and is absent issues no request. A target is absent when device >= ROOT_DEVS, or when bit device*8+function of `root_fn_map` is 0. A read of an absent target returns data 0xFFFFFFFF with `rsp_err`=0, and a write is dropped and acknowledged with data 0 and `rsp_err`=0. Either response comes one cycle after acceptance.
- R4: A configuration read whose completion has `cfg_cpl_ur`=1 returns 0xFFFFFFFF with `rsp_err`=0.
- R5: A configuration read whose completion has `cfg_cpl_ur`=0 returns `cfg_cpl_data`. A configuration write returns data 0. In both cases `rsp_err`=0 and the response comes one cycle after the completion.
- R6: An access in [OB_BASE, OB_BASE + 2^OB_LOG2) claimed by an enabled window i (base_i <= addr <= limit_i, bounds inclusive, lowest index wins) issues one `mem_req_valid` pulse. The pulse carries the identical address, the write flag, the write data and index i. The response then carries `mem_cpl_data` for reads, or 0 for writes, with `rsp_err`=0.
- R7: An outbound-region access that no enabled window claims, or an access that is in neither region, issues no request. It is answered one cycle after acceptance with `rsp_err`=1 and data 0. Any response with `rsp_err`=1 has data 0.
- R8: Once a request is accepted, `req_ready` stays 0 until the cycle in which its response is presented. At most one request is outstanding.
- R9: A downstream request with no completion by its TIMEOUT-th waiting cycle is answered on the next cycle. A configuration read then gets 0xFFFFFFFF, a configuration write gets 0, both with `rsp_err`=0. A memory access gets `rsp_err`=1 with data 0.
- R10: A completion of a kind that is not being waited for (`cfg_cpl_valid` or `mem_cpl_valid` while idle) produces no response and changes nothing.
- R11: Every accepted request gets exactly one response, presented as a single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Hart access request |
| req_ready | output | 1 | Bridge idle, request taken on this edge |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Hart physical address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access error |
| rsp_rdata | output | DW | Load data |
| root_fn_map | input | ROOT_DEVS*8 | Root-bus function present map, bit dev*8+fn |
| win_en | input | NWIN | Outbound window enables |
| win_base | input | NWIN*AW | Window lower bounds, inclusive |
| win_limit | input | NWIN*AW | Window upper bounds, inclusive |
| cfg_req_valid | output | 1 | Configuration request pulse |
| cfg_req_write | output | 1 | Configuration write |
| cfg_req_bus | output | 8 | Target bus |
| cfg_req_dev | output | 5 | Target device |
| cfg_req_fn | output | 3 | Target function |
| cfg_req_reg | output | 12 | Register byte offset |
| cfg_req_wdata | output | DW | Configuration write data |
| cfg_cpl_valid | input | 1 | Configuration completion |
| cfg_cpl_ur | input | 1 | Completion status is unsupported request |
| cfg_cpl_data | input | DW | Completion data |
| mem_req_valid | output | 1 | Outbound memory request pulse |
| mem_req_write | output | 1 | Outbound write |
| mem_req_addr | output | AW | Untranslated address |
| mem_req_wdata | output | DW | Outbound write data |
| mem_req_win | output | max(1,clog2(NWIN)) | Claiming window index |
| mem_cpl_valid | input | 1 | Outbound completion |
| mem_cpl_data | input | DW | Outbound read data |

## Verification
Several properties are checked on every cycle:
- a request is accepted only when nothing is outstanding;
- every response pulse belongs to an accepted request and does not repeat;
- configuration and memory requests never coincide;
- a request pulse always follows an acceptance;
- an error response never carries data;
- no request waits longer than the timeout window.

Other behaviours can only be shown by the scenarios, because they need the bench to compute expected values from the address and from the window and presence settings. These are:
- the bus/device/function/register slicing;
- the absent-target and unsupported-request substitution of all-ones;
- window claiming at the inclusive bounds;
- whether a disabled window is honoured;
- the exact latency of immediate, completed and timed-out responses;
- stray completions being ignored.

// File: rtl/hbx_pkg.sv
package hbx_pkg;

  // Fixed split of the configuration window offset
  localparam int unsigned BUS_W     = 8;
  localparam int unsigned DEV_W     = 5;
  localparam int unsigned FN_W      = 3;
  localparam int unsigned REGOFF_W  = 12;
  localparam int unsigned CFG_OFF_W = BUS_W + DEV_W + FN_W + REGOFF_W;

  // Packed MSB-first so that a cast of the window offset slices it directly
  typedef struct packed {
    logic [BUS_W-1:0]    bus;
    logic [DEV_W-1:0]    dev;
    logic [FN_W-1:0]     fn;
    logic [REGOFF_W-1:0] regoff;
  } cfg_tgt_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CFG  = 2'd1,
    TGT_MEM  = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CFG_WAIT = 2'd1,
    ST_MEM_WAIT = 2'd2
  } st_e;

endpackage

// File: rtl/hbx_decode.sv
module hbx_decode
  import hbx_pkg::*;
#(
  parameter int unsigned     AW        = 32,
  parameter logic [AW-1:0]   CFG_BASE  = 'h3000_0000,
  parameter logic [AW-1:0]   OB_BASE   = 'h4000_0000,
  parameter int unsigned     OB_LOG2   = 28,
  parameter int unsigned     ROOT_BUS  = 0,
  parameter int unsigned     ROOT_DEVS = 4,
  localparam int unsigned    MAPW      = ROOT_DEVS * 8,
  localparam int unsigned    MAPIW     = (MAPW > 1) ? $clog2(MAPW) : 1
) (
  input  logic [AW-1:0]   addr,
  input  logic [MAPW-1:0] fn_map,
  output tgt_e            tgt,
  output cfg_tgt_t        fields,
  output logic            root_absent
);

  logic       cfg_hit;
  logic       ob_hit;
  logic [7:0] flat_idx;
  logic       dev_in_range;

  assign cfg_hit = (addr[AW-1:CFG_OFF_W] == CFG_BASE[AW-1:CFG_OFF_W]);
  assign ob_hit  = (addr[AW-1:OB_LOG2]   == OB_BASE[AW-1:OB_LOG2]);
  assign fields  = cfg_tgt_t'(addr[CFG_OFF_W-1:0]);

  always_comb begin
    if (cfg_hit)     tgt = TGT_CFG;
    else if (ob_hit) tgt = TGT_MEM;
    else             tgt = TGT_NONE;
  end

  // Presence lookup on the root bus only; other buses are always forwarded
  assign flat_idx     = {fields.dev, fields.fn};
  assign dev_in_range = (32'(fields.dev) < ROOT_DEVS);

  always_comb begin
    root_absent = 1'b0;
    if (fields.bus == 8'(ROOT_BUS)) begin
      if (!dev_in_range) root_absent = 1'b1;
      else               root_absent = !fn_map[flat_idx[MAPIW-1:0]];
    end
  end

endmodule

// File: rtl/hbx_win_match.sv
module hbx_win_match #(
  parameter int unsigned  AW   = 32,
  parameter int unsigned  NWIN = 4,
  localparam int unsigned WIW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [AW-1:0]      addr,
  input  logic [NWIN-1:0]    en,
  input  logic [NWIN*AW-1:0] base,
  input  logic [NWIN*AW-1:0] limit,
  output logic               hit,
  output logic [WIW-1:0]     idx
);

  logic [NWIN-1:0] claim;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    assign lo       = base[g*AW +: AW];
    assign hi       = limit[g*AW +: AW];
    assign claim[g] = en[g] && (addr >= lo) && (addr <= hi);
  end

  // Lowest claiming index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (claim[i]) begin
        hit = 1'b1;
        idx = WIW'(i);
      end
    end
  end

endmodule

// File: rtl/hbx_tmo.sv
module hbx_tmo #(
  parameter int unsigned  TIMEOUT = 1024,
  localparam int unsigned CW      = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(TIMEOUT - 1));

endmodule

// File: rtl/hb_cfg_xlate.sv
module hb_cfg_xlate
  import hbx_pkg::*;
#(
  parameter int unsigned   AW        = 32,
  parameter int unsigned   DW        = 32,
  parameter int unsigned   NWIN      = 4,
  parameter int unsigned   ROOT_DEVS = 4,
  parameter int unsigned   ROOT_BUS  = 0,
  parameter logic [AW-1:0] CFG_BASE  = 'h3000_0000,
  parameter logic [AW-1:0] OB_BASE   = 'h4000_0000,
  parameter int unsigned   OB_LOG2   = 28,
  parameter int unsigned   TIMEOUT   = 1024,
  localparam int unsigned  MAPW      = ROOT_DEVS * 8,
  localparam int unsigned  WIW       = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DW-1:0]      rsp_rdata,
  input  logic [MAPW-1:0]    root_fn_map,
  input  logic [NWIN-1:0]    win_en,
  input  logic [NWIN*AW-1:0] win_base,
  input  logic [NWIN*AW-1:0] win_limit,
  output logic               cfg_req_valid,
  output logic               cfg_req_write,
  output logic [7:0]         cfg_req_bus,
  output logic [4:0]         cfg_req_dev,
  output logic [2:0]         cfg_req_fn,
  output logic [11:0]        cfg_req_reg,
  output logic [DW-1:0]      cfg_req_wdata,
  input  logic               cfg_cpl_valid,
  input  logic               cfg_cpl_ur,
  input  logic [DW-1:0]      cfg_cpl_data,
  output logic               mem_req_valid,
  output logic               mem_req_write,
  output logic [AW-1:0]      mem_req_addr,
  output logic [DW-1:0]      mem_req_wdata,
  output logic [WIW-1:0]     mem_req_win,
  input  logic               mem_cpl_valid,
  input  logic [DW-1:0]      mem_cpl_data
);

  localparam logic [DW-1:0] ALL_ONES = '1;

  st_e            state;
  tgt_e           tgt;
  cfg_tgt_t       fields;
  logic           root_absent;
  logic           win_hit;
  logic [WIW-1:0] win_idx;
  logic           tmo_expired;
  logic           pend_write;
  logic           waiting;

  hbx_decode #(
    .AW        (AW),
    .CFG_BASE  (CFG_BASE),
    .OB_BASE   (OB_BASE),
    .OB_LOG2   (OB_LOG2),
    .ROOT_BUS  (ROOT_BUS),
    .ROOT_DEVS (ROOT_DEVS)
  ) u_decode (
    .addr        (req_addr),
    .fn_map      (root_fn_map),
    .tgt         (tgt),
    .fields      (fields),
    .root_absent (root_absent)
  );

  hbx_win_match #(
    .AW   (AW),
    .NWIN (NWIN)
  ) u_match (
    .addr  (req_addr),
    .en    (win_en),
    .base  (win_base),
    .limit (win_limit),
    .hit   (win_hit),
    .idx   (win_idx)
  );

  assign waiting = (state != ST_IDLE);

  hbx_tmo #(
    .TIMEOUT (TIMEOUT)
  ) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .run     (waiting),
    .expired (tmo_expired)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pend_write    <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_rdata     <= '0;
      cfg_req_valid <= 1'b0;
      cfg_req_write <= 1'b0;
      cfg_req_bus   <= '0;
      cfg_req_dev   <= '0;
      cfg_req_fn    <= '0;
      cfg_req_reg   <= '0;
      cfg_req_wdata <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      mem_req_win   <= '0;
    end else begin
      rsp_valid     <= 1'b0;
      cfg_req_valid <= 1'b0;
      mem_req_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            pend_write <= req_write;
            unique case (tgt)
              TGT_CFG: begin
                if (root_absent) begin
                  // Absent root-bus target: answer locally, nothing issued
                  rsp_valid <= 1'b1;
                  rsp_err   <= 1'b0;
                  rsp_rdata <= req_write ? '0 : ALL_ONES;
                end else begin
                  cfg_req_valid <= 1'b1;
                  cfg_req_write <= req_write;
                  cfg_req_bus   <= fields.bus;
                  cfg_req_dev   <= fields.dev;
                  cfg_req_fn    <= fields.fn;
                  cfg_req_reg   <= fields.regoff;
                  cfg_req_wdata <= req_wdata;
                  state         <= ST_CFG_WAIT;
                end
              end
              TGT_MEM: begin
                if (win_hit) begin
                  mem_req_valid <= 1'b1;
                  mem_req_write <= req_write;
                  mem_req_addr  <= req_addr;
                  mem_req_wdata <= req_wdata;
                  mem_req_win   <= win_idx;
                  state         <= ST_MEM_WAIT;
                end else begin
                  rsp_valid <= 1'b1;
                  rsp_err   <= 1'b1;
                  rsp_rdata <= '0;
                end
              end
              default: begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b1;
                rsp_rdata <= '0;
              end
            endcase
          end
        end
        ST_CFG_WAIT: begin
          if (cfg_cpl_valid) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            if (pend_write)      rsp_rdata <= '0;
            else if (cfg_cpl_ur) rsp_rdata <= ALL_ONES;
            else                 rsp_rdata <= cfg_cpl_data;
            state <= ST_IDLE;
          end else if (tmo_expired) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= pend_write ? '0 : ALL_ONES;
            state     <= ST_IDLE;
          end
        end
        ST_MEM_WAIT: begin
          if (mem_cpl_valid) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= pend_write ? '0 : mem_cpl_data;
            state     <= ST_IDLE;
          end else if (tmo_expired) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hbx_checker.sv
module hbx_checker #(
  parameter int unsigned DW      = 32,
  parameter int unsigned TIMEOUT = 1024
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [DW-1:0] rsp_rdata,
  input logic          cfg_req_valid,
  input logic          mem_req_valid
);

  logic        pend;
  logic [31:0] wait_cnt;
  logic        accept;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      wait_cnt <= '0;
    end else begin
      pend <= (pend && !rsp_valid) || accept;
      if (rsp_valid || !pend) wait_cnt <= '0;
      else                    wait_cnt <= wait_cnt + 1;
    end
  end

  // R8: a new request is taken only when the previous one is answering
  a_r8_accept_when_free: assert property (@(posedge clk) disable iff (rst)
    accept |-> (!pend || rsp_valid));

  // R8: bridge is busy while a downstream request is in flight
  a_r8_busy_on_issue: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_valid || mem_req_valid) |-> !req_ready);

  // R11: a response always belongs to an accepted request
  a_r11_rsp_owned: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> pend);

  // R11: a response is a single-cycle pulse
  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !accept) |=> !rsp_valid);

  // R7: error responses carry no data
  a_r7_err_no_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  // R2 / R6: at most one downstream request kind at once
  a_r2_single_kind: assert property (@(posedge clk) disable iff (rst)
    !(cfg_req_valid && mem_req_valid));

  // R2: a downstream request follows an acceptance
  a_r2_issue_after_accept: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_valid || mem_req_valid) |-> $past(accept));

  // R9: no request waits past the timeout window
  a_r9_bounded_wait: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= 32'(TIMEOUT + 1));

endmodule

bind hb_cfg_xlate hbx_checker #(
  .DW      (DW),
  .TIMEOUT (TIMEOUT)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_err       (rsp_err),
  .rsp_rdata     (rsp_rdata),
  .cfg_req_valid (cfg_req_valid),
  .mem_req_valid (mem_req_valid)
);

// File: tb/hb_cfg_xlate_tb_top.sv
`timescale 1ns/1ps
module hb_cfg_xlate_tb_top;

  localparam int unsigned AW   = 32;
  localparam int unsigned DW   = 32;
  localparam int unsigned NWIN = 4;
  localparam int unsigned RDEV = 4;
  localparam int unsigned TMO  = 16;
  localparam int unsigned WIW  = 2;

  // mode: 0 no downstream reply expected, 1 good completion,
  //       2 unsupported-request completion, 3 never complete
  // kind: 0 answered locally, 1 configuration request, 2 memory request
  typedef struct packed {
    logic [3:0]  rq;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  mode;
    logic [31:0] cdata;
    logic [1:0]  kind;
    logic        err;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd5, 1'b0, 32'h3000_0000, 32'h0,        2'd1, 32'h1234_ABCD, 2'd1, 1'b0, 32'h1234_ABCD}, // R5 read dev0
    '{4'd2, 1'b1, 32'h3000_9010, 32'hCAFE_0001, 2'd1, 32'h0,        2'd1, 1'b0, 32'h0},         // R2 write dev1 fn1
    '{4'd3, 1'b0, 32'h3001_0000, 32'h0,        2'd0, 32'h0,        2'd0, 1'b0, 32'hFFFF_FFFF}, // R3 absent fn
    '{4'd3, 1'b0, 32'h3003_8000, 32'h0,        2'd0, 32'h0,        2'd0, 1'b0, 32'hFFFF_FFFF}, // R3 dev beyond range
    '{4'd3, 1'b1, 32'h3001_0004, 32'h0BAD_0BAD, 2'd0, 32'h0,        2'd0, 1'b0, 32'h0},         // R3 write dropped
    '{4'd4, 1'b0, 32'h3000_8008, 32'h0,        2'd2, 32'h1234_5678, 2'd1, 1'b0, 32'hFFFF_FFFF}, // R4 UR
    '{4'd2, 1'b0, 32'h3051_A0FC, 32'h0,        2'd1, 32'h55AA_0FF0, 2'd1, 1'b0, 32'h55AA_0FF0}, // R2 other bus
    '{4'd9, 1'b0, 32'h3030_0000, 32'h0,        2'd3, 32'h0,        2'd1, 1'b0, 32'hFFFF_FFFF}, // R9 cfg timeout
    '{4'd6, 1'b0, 32'h4000_1000, 32'h0,        2'd1, 32'hDEAD_BEEF, 2'd2, 1'b0, 32'hDEAD_BEEF}, // R6 window 0
    '{4'd6, 1'b1, 32'h4800_FFFC, 32'hA5A5_A5A5, 2'd1, 32'h0,        2'd2, 1'b0, 32'h0},         // R6 window 1 top
    '{4'd7, 1'b0, 32'h4400_0000, 32'h0,        2'd0, 32'h0,        2'd0, 1'b1, 32'h0},         // R7 disabled window
    '{4'd7, 1'b1, 32'h1000_0000, 32'h77,       2'd0, 32'h0,        2'd0, 1'b1, 32'h0},         // R7 no region
    '{4'd9, 1'b0, 32'h4800_0000, 32'h0,        2'd3, 32'h0,        2'd2, 1'b1, 32'h0},         // R9 mem timeout
    '{4'd7, 1'b0, 32'h4010_0000, 32'h0,        2'd0, 32'h0,        2'd0, 1'b1, 32'h0},         // R7 just above limit
    '{4'd6, 1'b0, 32'h400F_FFFC, 32'h0,        2'd1, 32'h0BAD_F00D, 2'd2, 1'b0, 32'h0BAD_F00D}  // R6 at limit
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic               req_write = 1'b0;
  logic [AW-1:0]      req_addr = '0;
  logic [DW-1:0]      req_wdata = '0;
  logic               rsp_valid;
  logic               rsp_err;
  logic [DW-1:0]      rsp_rdata;
  logic [RDEV*8-1:0]  root_fn_map;
  logic [NWIN-1:0]    win_en;
  logic [NWIN*AW-1:0] win_base;
  logic [NWIN*AW-1:0] win_limit;
  logic               cfg_req_valid;
  logic               cfg_req_write;
  logic [7:0]         cfg_req_bus;
  logic [4:0]         cfg_req_dev;
  logic [2:0]         cfg_req_fn;
  logic [11:0]        cfg_req_reg;
  logic [DW-1:0]      cfg_req_wdata;
  logic               cfg_cpl_valid = 1'b0;
  logic               cfg_cpl_ur = 1'b0;
  logic [DW-1:0]      cfg_cpl_data = '0;
  logic               mem_req_valid;
  logic               mem_req_write;
  logic [AW-1:0]      mem_req_addr;
  logic [DW-1:0]      mem_req_wdata;
  logic [WIW-1:0]     mem_req_win;
  logic               mem_cpl_valid = 1'b0;
  logic [DW-1:0]      mem_cpl_data = '0;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  // dev0 fn0, dev1 fn0, dev1 fn1 present on the root bus
  assign root_fn_map = 32'h0000_0301;
  assign win_en      = 4'b0011;
  assign win_base    = {32'h0, 32'h4400_0000, 32'h4800_0000, 32'h4000_0000};
  assign win_limit   = {32'h0, 32'h44FF_FFFF, 32'h4800_FFFF, 32'h400F_FFFF};

  hb_cfg_xlate #(
    .AW(AW), .DW(DW), .NWIN(NWIN), .ROOT_DEVS(RDEV), .TIMEOUT(TMO)
  ) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .root_fn_map(root_fn_map), .win_en(win_en), .win_base(win_base), .win_limit(win_limit),
    .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write), .cfg_req_bus(cfg_req_bus),
    .cfg_req_dev(cfg_req_dev), .cfg_req_fn(cfg_req_fn), .cfg_req_reg(cfg_req_reg),
    .cfg_req_wdata(cfg_req_wdata),
    .cfg_cpl_valid(cfg_cpl_valid), .cfg_cpl_ur(cfg_cpl_ur), .cfg_cpl_data(cfg_cpl_data),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_win(mem_req_win),
    .mem_cpl_valid(mem_cpl_valid), .mem_cpl_data(mem_cpl_data)
  );

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit          got_cfg = 0;
    bit          got_mem = 0;
    bit          got_rsp = 0;
    bit          busy_ok = 1;
    logic [31:0] rd  = '0;
    logic        er  = 1'b0;
    int          lat = -1;
    string       tag;
    tag = $sformatf("R%0d vec %h", v.rq, v.addr);
    @(negedge clk);
    check(req_ready == 1'b1, {tag, " ready (R8)"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = v.addr;
    req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 64 && !got_rsp; c++) begin
      if (!rsp_valid && req_ready) busy_ok = 0;
      if (cfg_req_valid) begin
        got_cfg = 1;
        // R2 field slicing
        check({cfg_req_bus, cfg_req_dev, cfg_req_fn, cfg_req_reg} == v.addr[27:0],
              {tag, " cfg fields (R2)"},
              64'({cfg_req_bus, cfg_req_dev, cfg_req_fn, cfg_req_reg}), 64'(v.addr[27:0]));
        check(cfg_req_write == v.wr && (!v.wr || cfg_req_wdata == v.wdata),
              {tag, " cfg write/data (R2)"}, 64'(cfg_req_wdata), 64'(v.wdata));
        if (v.mode == 2'd1 || v.mode == 2'd2) begin
          cfg_cpl_valid = 1'b1;
          cfg_cpl_ur    = (v.mode == 2'd2);
          cfg_cpl_data  = v.cdata;
        end
      end
      if (mem_req_valid) begin
        got_mem = 1;
        // R6 untranslated forwarding and window index
        check(mem_req_addr == v.addr && mem_req_write == v.wr && (!v.wr || mem_req_wdata == v.wdata),
              {tag, " mem addr (R6)"}, 64'(mem_req_addr), 64'(v.addr));
        check(mem_req_win == ((v.addr[31:24] == 8'h48) ? 2'd1 : 2'd0),
              {tag, " mem window (R6)"}, 64'(mem_req_win), 64'((v.addr[31:24] == 8'h48) ? 1 : 0));
        if (v.mode == 2'd1) begin
          mem_cpl_valid = 1'b1;
          mem_cpl_data  = v.cdata;
        end
      end
      if (rsp_valid) begin
        got_rsp = 1;
        rd  = rsp_rdata;
        er  = rsp_err;
        lat = c;
      end
      @(negedge clk);
      cfg_cpl_valid = 1'b0;
      cfg_cpl_ur    = 1'b0;
      mem_cpl_valid = 1'b0;
    end
    check(got_rsp, {tag, " response (R11)"}, 64'(got_rsp), 64'd1);
    check(busy_ok, {tag, " busy while pending (R8)"}, 64'(busy_ok), 64'd1);
    check(got_cfg == (v.kind == 2'd1) && got_mem == (v.kind == 2'd2),
          {tag, " request kind"}, 64'({got_mem, got_cfg}), 64'(v.kind));
    check(er == v.err, {tag, " err"}, 64'(er), 64'(v.err));
    check(rd == v.rdata, {tag, " rdata"}, 64'(rd), 64'(v.rdata));
    begin
      int exp_lat;
      if (v.mode == 2'd0)      exp_lat = 0;
      else if (v.mode == 2'd3) exp_lat = TMO;
      else                     exp_lat = 1;
      check(lat == exp_lat, {tag, " latency"}, 64'(lat), 64'(exp_lat));
    end
    // R11 single pulse
    check(rsp_valid == 1'b0, {tag, " pulse (R11)"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && cfg_req_valid == 1'b0 && mem_req_valid == 1'b0,
          "R1 reset state", 64'({req_ready, rsp_valid, cfg_req_valid, mem_req_valid}), 64'h8);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10 stray completions while idle
    @(negedge clk);
    cfg_cpl_valid = 1'b1;
    cfg_cpl_data  = 32'h1111_2222;
    mem_cpl_valid = 1'b1;
    mem_cpl_data  = 32'h3333_4444;
    @(negedge clk);
    cfg_cpl_valid = 1'b0;
    mem_cpl_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 stray completion ignored",
            64'({rsp_valid, req_ready}), 64'h1);
      @(negedge clk);
    end
    // R10 bridge still answers normally afterwards
    run_vec(VECS[0]);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule